// File: doc/BRIEF.md
# Synchronous Bus Clock Prescaler with Module Gating

This block derives four clock-enable domains from a single main clock: a processor domain, a high-speed bus domain and two peripheral bus domains (A and B). Each domain has its own power-of-two prescaler, driven by one shared free-running counter. Every domain drives a per-cycle enable pulse. Below that sits a bank of per-module enables, each gated by one bit of that domain's module mask. Logic downstream uses these enables as clock enables. No derived clocks are generated.

Software programs the block through a small synchronous register port. One configuration word holds the prescaler settings for all four domains and a main-source flag. The flag is kept only as state for the surrounding clock logic: 1 means the PLL and 0 means the oscillator. Four mask words follow, one per domain. A configuration write that would let a child domain run faster than its parent is dropped, and a sticky error flag records it. Mask updates are held back until the affected domain's next enable pulse has ended. A pulse is therefore never cut short or stretched.

Top module: `bclk_gen`

## Requirements
- R1: After reset, the configuration word reads zero, `main_pll` and `cfg_err` are 0, the prescaler counter is 0, and each mask word reads its always-on parameter value (`AON_CPU`, `AON_HSB`, `AON_PBA`, `AON_PBB`).
- R2: When a domain's divide-enable bit is 0, its `dom_en` bit is 1 on every cycle, so the domain runs at the full main rate.
- R3: When a domain's divide-enable bit is 1 with select value s, its `dom_en` bit is 1 exactly on the cycles where the low s+1 bits of the 8-bit prescaler counter are all ones. The counter starts at 0 after reset and counts up once per cycle. This gives one pulse every 2^(s+1) cycles.
- R4: The configuration word is at address 0. Domain d (0 = CPU, 1 = HSB, 2 = PBA, 3 = PBB) has its 3-bit select value in bits 4d+2..4d and its divide-enable bit in bit 4d+3. Bit 16 is the main-source flag and drives `main_pll`. Bit 31 reads back `cfg_err`, and all other bits read 0. `dom_en` bit d belongs to domain d.
- R5: A configuration write is dropped entirely when the resulting periods do not satisfy CPU <= HSB <= PBA and HSB <= PBB. Here a domain's period is 1 when divide-enable is 0, and 2^(s+1) otherwise.
- R6: A dropped configuration write sets `cfg_err`, which stays 1 until reset.
- R7: The mask words are at addresses 1 (CPU), 2 (HSB), 3 (PBA) and 4 (PBB). Bit n of a mask word enables module n of that domain. A write to addresses 5 to 7 has no effect on any register.
- R8: A module enable (`mod_en_*` bit n) is 1 only in a cycle where its domain's `dom_en` bit is 1 and bit n of the domain's applied mask is 1.
- R9: A mask write becomes the applied mask only at the clock edge that ends a pulse of that domain. The first pulse of that domain after the write still uses the previous mask.
- R10: `rd_data` returns the addressed register combinationally from `rd_addr`. It returns 0 for addresses 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | MASK_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | MASK_W | Read data of the addressed register |
| main_pll | output | 1 | Main-source flag (1 = PLL, 0 = oscillator) |
| cfg_err | output | 1 | Sticky flag for a rejected configuration write |
| dom_en | output | 4 | Per-domain enable pulses (CPU, HSB, PBA, PBB) |
| mod_en_cpu | output | MASK_W | Gated module enables, CPU domain |
| mod_en_hsb | output | MASK_W | Gated module enables, HSB domain |
| mod_en_pba | output | MASK_W | Gated module enables, PBA domain |
| mod_en_pbb | output | MASK_W | Gated module enables, PBB domain |

## Verification
The assertions check several invariants on every cycle:
- the stored prescaler settings always keep the parent-before-child rate order;
- a rejected write leaves the settings unchanged and raises the sticky error flag;
- a domain that is not dividing pulses continuously;
- a divided domain never pulses on two cycles in a row while its setting holds;
- the applied masks only move at pulse edges and no module enable appears outside its domain pulse.

Only the bench scenarios can show the exact pulse phase against the counter, the one-pulse delay of a mask update, the register layout on readback, and that writes to unused addresses leave every register unchanged.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  localparam int NDOM    = 4;
  localparam int SEL_W   = 3;
  localparam int FLD_W   = SEL_W + 1;
  localparam int CNT_W   = 2 ** SEL_W;
  localparam int SHIFT_W = $clog2(CNT_W + 1);
  localparam int FIELDS_W = NDOM * FLD_W;

  typedef enum logic [1:0] {DOM_CPU = 2'd0, DOM_HSB = 2'd1, DOM_PBA = 2'd2, DOM_PBB = 2'd3} dom_e;

  // Shift amount of one domain field: 0 when not dividing, sel+1 otherwise.
  function automatic logic [SHIFT_W-1:0] field_shift(input logic [FLD_W-1:0] fld);
    return fld[FLD_W-1] ? (SHIFT_W'(fld[SEL_W-1:0]) + SHIFT_W'(1)) : '0;
  endfunction

  // Parent domains never slower than their children.
  function automatic logic fields_ordered(input logic [FIELDS_W-1:0] f);
    logic [SHIFT_W-1:0] s [NDOM];
    for (int d = 0; d < NDOM; d++) s[d] = field_shift(f[d*FLD_W +: FLD_W]);
    return (s[DOM_CPU] <= s[DOM_HSB]) && (s[DOM_HSB] <= s[DOM_PBA]) &&
           (s[DOM_HSB] <= s[DOM_PBB]);
  endfunction

  // Counter low 'sh' bits all ones.
  function automatic logic tick_hit(input logic [CNT_W-1:0] cnt, input logic [SHIFT_W-1:0] sh);
    logic [CNT_W:0] one;
    logic [CNT_W:0] m;
    one = {{CNT_W{1'b0}}, 1'b1};
    m   = (one << sh) - one;
    return (cnt & m[CNT_W-1:0]) == m[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/bclk_regs.sv
module bclk_regs
  import bclk_pkg::*;
#(
  parameter int MASK_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [NDOM*MASK_W-1:0] AON_INIT = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [MASK_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [MASK_W-1:0]      rd_data,
  output logic [FIELDS_W-1:0]    fields,
  output logic                   main_pll,
  output logic                   cfg_err,
  output logic                   wr_reject,
  output logic [NDOM*MASK_W-1:0] shadow
);
  localparam int MAIN_BIT = FIELDS_W;
  localparam int ERR_BIT  = MASK_W - 1;

  logic [FIELDS_W-1:0] fld_q;
  logic                main_q;
  logic                err_q;
  logic [MASK_W-1:0]   mask_q [NDOM];
  logic                sel_wr;

  assign sel_wr    = wr_en && (wr_addr == '0);
  assign wr_reject = sel_wr && !fields_ordered(wr_data[FIELDS_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q  <= '0;
      main_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (wr_reject) begin
      err_q  <= 1'b1;
    end else if (sel_wr) begin
      fld_q  <= wr_data[FIELDS_W-1:0];
      main_q <= wr_data[MAIN_BIT];
    end
  end

  for (genvar d = 0; d < NDOM; d++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mask_q[d] <= AON_INIT[d*MASK_W +: MASK_W];
      else if (wr_en && (wr_addr == ADDR_W'(d + 1)))
        mask_q[d] <= wr_data;
    end
    assign shadow[d*MASK_W +: MASK_W] = mask_q[d];
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) begin
      rd_data[FIELDS_W-1:0] = fld_q;
      rd_data[MAIN_BIT]     = main_q;
      rd_data[ERR_BIT]      = err_q;
    end
    for (int d = 0; d < NDOM; d++)
      if (rd_addr == ADDR_W'(d + 1)) rd_data = mask_q[d];
  end

  assign fields   = fld_q;
  assign main_pll = main_q;
  assign cfg_err  = err_q;
endmodule

// File: rtl/bclk_prescaler.sv
module bclk_prescaler
  import bclk_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [FIELDS_W-1:0]     fields,
  output logic [NDOM-1:0]         dom_tick,
  output logic [NDOM*SHIFT_W-1:0] dom_shift
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    logic [SHIFT_W-1:0] sh;
    assign sh = field_shift(fields[d*FLD_W +: FLD_W]);
    assign dom_shift[d*SHIFT_W +: SHIFT_W] = sh;
    assign dom_tick[d] = tick_hit(cnt_q, sh);
  end
endmodule

// File: rtl/bclk_gate.sv
module bclk_gate #(
  parameter int MASK_W = 32,
  parameter logic [MASK_W-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [MASK_W-1:0] shadow,
  output logic [MASK_W-1:0] active,
  output logic [MASK_W-1:0] mod_en
);
  // The applied mask only moves on the edge that closes a pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    active <= INIT;
    else if (tick) active <= shadow;
  end

  assign mod_en = {MASK_W{tick}} & active;
endmodule

// File: rtl/bclk_gen.sv
module bclk_gen
  import bclk_pkg::*;
#(
  parameter int MASK_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [MASK_W-1:0] AON_CPU = 32'h0000_0001,
  parameter logic [MASK_W-1:0] AON_HSB = 32'h0000_0003,
  parameter logic [MASK_W-1:0] AON_PBA = 32'h0000_0000,
  parameter logic [MASK_W-1:0] AON_PBB = 32'h0000_0006
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [MASK_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [MASK_W-1:0] rd_data,
  output logic              main_pll,
  output logic              cfg_err,
  output logic [3:0]        dom_en,
  output logic [MASK_W-1:0] mod_en_cpu,
  output logic [MASK_W-1:0] mod_en_hsb,
  output logic [MASK_W-1:0] mod_en_pba,
  output logic [MASK_W-1:0] mod_en_pbb
);
  localparam logic [NDOM*MASK_W-1:0] AON_ALL = {AON_PBB, AON_PBA, AON_HSB, AON_CPU};

  logic [FIELDS_W-1:0]     fields;
  logic                    wr_reject;
  logic [NDOM*MASK_W-1:0]  shadow;
  logic [NDOM*SHIFT_W-1:0] dom_shift;
  logic [NDOM-1:0]         dom_tick;
  logic [NDOM*MASK_W-1:0]  act_mask;
  logic [NDOM*MASK_W-1:0]  all_mod;

  bclk_regs #(.MASK_W(MASK_W), .ADDR_W(ADDR_W), .AON_INIT(AON_ALL)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fields(fields), .main_pll(main_pll),
    .cfg_err(cfg_err), .wr_reject(wr_reject), .shadow(shadow)
  );

  bclk_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .fields(fields), .dom_tick(dom_tick), .dom_shift(dom_shift)
  );

  for (genvar d = 0; d < NDOM; d++) begin : g_gate
    bclk_gate #(.MASK_W(MASK_W), .INIT(AON_ALL[d*MASK_W +: MASK_W])) u_gate (
      .clk(clk), .rst_n(rst_n), .tick(dom_tick[d]),
      .shadow(shadow[d*MASK_W +: MASK_W]),
      .active(act_mask[d*MASK_W +: MASK_W]),
      .mod_en(all_mod[d*MASK_W +: MASK_W])
    );
  end

  assign dom_en     = dom_tick;
  assign mod_en_cpu = all_mod[DOM_CPU*MASK_W +: MASK_W];
  assign mod_en_hsb = all_mod[DOM_HSB*MASK_W +: MASK_W];
  assign mod_en_pba = all_mod[DOM_PBA*MASK_W +: MASK_W];
  assign mod_en_pbb = all_mod[DOM_PBB*MASK_W +: MASK_W];
endmodule

// File: rtl/bclk_gen_chk.sv
module bclk_gen_chk
  import bclk_pkg::*;
#(
  parameter int MASK_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NDOM-1:0]         dom_en,
  input logic [NDOM*SHIFT_W-1:0] dom_shift,
  input logic                    wr_reject,
  input logic                    cfg_err,
  input logic                    main_pll,
  input logic [NDOM*MASK_W-1:0]  act_mask,
  input logic [NDOM*MASK_W-1:0]  all_mod
);
  logic [SHIFT_W-1:0] s_cpu, s_hsb, s_pba, s_pbb;
  assign s_cpu = dom_shift[DOM_CPU*SHIFT_W +: SHIFT_W];
  assign s_hsb = dom_shift[DOM_HSB*SHIFT_W +: SHIFT_W];
  assign s_pba = dom_shift[DOM_PBA*SHIFT_W +: SHIFT_W];
  assign s_pbb = dom_shift[DOM_PBB*SHIFT_W +: SHIFT_W];

  assert_order_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_cpu <= s_hsb) && (s_hsb <= s_pba) && (s_hsb <= s_pbb));

  assert_reject_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> ($stable(dom_shift) && $stable(main_pll)));

  assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> cfg_err);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    assert_full_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dom_shift[d*SHIFT_W +: SHIFT_W] == '0) |-> dom_en[d]);

    assert_pulse_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dom_en[d] && (dom_shift[d*SHIFT_W +: SHIFT_W] != '0)) |=>
        (!dom_en[d] || !$stable(dom_shift[d*SHIFT_W +: SHIFT_W])));

    assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !dom_en[d] |-> (all_mod[d*MASK_W +: MASK_W] == '0));

    assert_active_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !dom_en[d] |=> $stable(act_mask[d*MASK_W +: MASK_W]));
  end
endmodule

bind bclk_gen bclk_gen_chk #(.MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dom_en(dom_en), .dom_shift(dom_shift),
  .wr_reject(wr_reject), .cfg_err(cfg_err), .main_pll(main_pll),
  .act_mask(act_mask), .all_mod(all_mod)
);

// File: tb/tb_bclk_gen.sv
module tb_bclk_gen;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] A_CPU = 32'h0000_0001;
  localparam logic [31:0] A_HSB = 32'h0000_0003;
  localparam logic [31:0] A_PBA = 32'h0000_0000;
  localparam logic [31:0] A_PBB = 32'h0000_0006;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        main_pll, cfg_err;
  logic [3:0]  dom_en;
  logic [31:0] mod_en_cpu, mod_en_hsb, mod_en_pba, mod_en_pbb;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit live = 0;

  bclk_gen #(.MASK_W(32), .ADDR_W(3), .AON_CPU(A_CPU), .AON_HSB(A_HSB),
             .AON_PBA(A_PBA), .AON_PBB(A_PBB)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .main_pll(main_pll), .cfg_err(cfg_err),
    .dom_en(dom_en), .mod_en_cpu(mod_en_cpu), .mod_en_hsb(mod_en_hsb),
    .mod_en_pba(mod_en_pba), .mod_en_pbb(mod_en_pbb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference state
  int          m_cnt = 0;
  logic [15:0] m_fld = '0;
  logic        m_main = 1'b0;
  logic        m_err = 1'b0;
  logic [31:0] m_shadow [4] = '{A_CPU, A_HSB, A_PBA, A_PBB};
  logic [31:0] m_active [4] = '{A_CPU, A_HSB, A_PBA, A_PBB};

  function automatic int period_of(input logic [3:0] f);
    return f[3] ? (2 << f[2:0]) : 1;
  endfunction

  function automatic bit legal(input logic [15:0] f);
    int p0, p1, p2, p3;
    p0 = period_of(f[3:0]); p1 = period_of(f[7:4]);
    p2 = period_of(f[11:8]); p3 = period_of(f[15:12]);
    return (p0 <= p1) && (p1 <= p2) && (p1 <= p3);
  endfunction

  function automatic bit m_tick(input int d);
    return ((m_cnt + 1) % period_of(m_fld[d*4 +: 4])) == 0;
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    if (a == 3'd0) return {m_err, 14'd0, m_main, m_fld};
    if (a >= 3'd1 && a <= 3'd4) return m_shadow[a - 1];
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_fld = '0; m_main = 0; m_err = 0;
      m_shadow = '{A_CPU, A_HSB, A_PBA, A_PBB};
      m_active = '{A_CPU, A_HSB, A_PBA, A_PBB};
    end else begin
      for (int d = 0; d < 4; d++) if (m_tick(d)) m_active[d] = m_shadow[d];
      m_cnt = (m_cnt + 1) % 256;
      if (wr_en) begin
        if (wr_addr == 3'd0) begin
          if (legal(wr_data[15:0])) begin m_fld = wr_data[15:0]; m_main = wr_data[16]; end
          else m_err = 1'b1;
        end else if (wr_addr <= 3'd4) m_shadow[wr_addr - 1] = wr_data;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-cycle comparison of all outputs (R2 R3 R4 R6 R8 R9)
  always @(negedge clk) begin
    if (live && rst_n) begin
      logic [133:0] a, e;
      logic [3:0] te;
      for (int d = 0; d < 4; d++) te[d] = m_tick(d);
      e = {te, {32{te[3]}} & m_active[3], {32{te[2]}} & m_active[2],
           {32{te[1]}} & m_active[1], {32{te[0]}} & m_active[0], m_main, m_err};
      a = {dom_en, mod_en_pbb, mod_en_pba, mod_en_hsb, mod_en_cpu, main_pll, cfg_err};
      check(a == e, "R2 R3 R4 R6 R8 R9 cycle", 160'(a), 160'(e));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input string req);
    @(negedge clk); rd_addr = a; #1;
    check(rd_data == m_read(a), req, 160'(rd_data), 160'(m_read(a)));
  endtask

  task automatic wait_pulse(input int d);
    int n = 0;
    do begin @(negedge clk); #1; n++; end while (!dom_en[d] && n < 600);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    live = 1'b1;
    // R1 reset state
    #1;
    check(dom_en == 4'hF && mod_en_cpu == A_CPU && mod_en_pbb == A_PBB && !cfg_err && !main_pll,
          "R1 reset outputs", 160'({dom_en, mod_en_cpu, mod_en_pbb}), 160'({4'hF, A_CPU, A_PBB}));
    for (int a = 0; a < 5; a++) rd_chk(3'(a), "R1 R10 reset readback");

    // R4 legal config: CPU /2, HSB /4, PBA /8, PBB /4, PLL source
    wr(3'd0, 32'h0001_9A98);
    rd_chk(3'd0, "R4 config readback");
    check(main_pll == 1'b1, "R4 main flag", 160'(main_pll), 160'(1));
    wr(3'd3, 32'hFFFF_0000);
    wr(3'd1, 32'h0000_00F0);
    repeat (40) @(negedge clk);
    rd_chk(3'd3, "R7 PBA mask readback");

    // R5 R6 illegal: CPU /16 slower than HSB /2
    wr(3'd0, 32'h0000_0080 | 32'h0000_000B);
    rd_chk(3'd0, "R5 R6 rejected write");
    check(cfg_err == 1'b1 && main_pll == 1'b1, "R6 sticky err", 160'({cfg_err, main_pll}), 160'(2'b11));

    // R7 unused addresses ignored
    wr(3'd5, 32'hDEAD_BEEF); wr(3'd7, 32'h1234_5678);
    for (int a = 0; a < 8; a++) rd_chk(3'(a), "R7 R10 unused address ignored");

    // R9 directed: PBB /256 only
    wr(3'd0, 32'h0000_F000);
    wr(3'd4, 32'h0000_00FF);
    wait_pulse(3); wait_pulse(3); @(negedge clk);
    wr(3'd4, 32'hA5A5_0000);
    wait_pulse(3);
    check(mod_en_pbb == 32'h0000_00FF, "R9 first pulse keeps old mask",
          160'(mod_en_pbb), 160'(32'hFF));
    @(negedge clk); #1;
    check(mod_en_pbb == 32'd0, "R8 no enable between pulses", 160'(mod_en_pbb), 160'(0));
    wait_pulse(3);
    check(mod_en_pbb == 32'hA5A5_0000, "R9 next pulse uses new mask",
          160'(mod_en_pbb), 160'(32'hA5A5_0000));

    // Random mix
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 9);
      if (k < 4) begin
        logic [31:0] v = $urandom;
        v[31:17] = '0;
        if (k == 0) v[15:0] = 16'h0000;
        wr(3'd0, v);
      end else if (k < 8) wr(3'($urandom_range(1, 4)), $urandom);
      else wr(3'($urandom_range(5, 7)), $urandom);
      repeat ($urandom_range(0, 12)) @(negedge clk);
      if (i % 20 == 0)
        for (int a = 0; a < 8; a++) rd_chk(3'(a), "R4 R7 R10 random readback");
    end

    repeat (300) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule